// File: doc/BRIEF.md
# Timer Overflow Flag Controller

The block is a free-running modulo up-counter with a small register window on a simple read/write bus. A clock-select field picks what advances the counter: nothing, every system clock, or an external tick strobe. A prescaler field then divides that source by a power of two. The counter climbs from zero to a programmable limit, includes that limit, and returns to zero on the next advance. Every return to zero sets a sticky overflow flag, and an enable bit routes the flag to an interrupt request line.

Software clears the flag in two steps. First it reads the status word while the flag shows 1, which arms the clear. Then it writes the status word with the flag bit at 0. The arm is used up by the next status write, whatever that write carries. A wrap that lands after the arming read and before the clearing write cancels the arm. The flag then stays set, so an overflow that arrives while an earlier one is being serviced is never dropped.

Top module: `ovf_timer_ctrl`

## Requirements
- R1: After reset the status word, the limit register, the counter and the interrupt output are all zero.
- R2: On each advance event the counter goes up by one. An advance with the counter equal to or above the limit sets it to 0 instead.
- R3: The overflow flag becomes 1 on the same clock edge at which the counter wraps to 0.
- R4: Status bits 4:3 select the advance source: 0 stops the counter, 1 advances it on every clock, 2 and 3 advance it on each clock with `tick_in` high.
- R5: Status bits 2:0 hold a value p, and the counter advances once per 2^p events of the selected source.
- R6: The flag (status bit 7) becomes 0 only when a write to the status word has bit 7 at 0 and follows a status read that returned the flag as 1.
- R7: A status write with bit 7 at 1 never changes the flag. A status write with bit 7 at 0 and no arming read since the flag last set leaves the flag at 1. Any status write uses up a pending arm.
- R8: A wrap between the arming read and the clearing write, or in the same cycle as that write, keeps the flag at 1.
- R9: `ovf_irq` is high exactly while both the flag and the enable bit (status bit 6) are 1. Changing the enable bit does not change the flag.
- R10: The status word sits at byte address 0x0. Bits 31:8 and bit 5 read as zero and ignore writes. Bits 6, 4:3 and 2:0 read back as written.
- R11: The limit register sits at address 0x4 and reads back its low CNT_W bits zero-extended. The counter reads at address 0x8, and writes to that address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | External advance strobe, one clock wide per event |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a wrap that falls inside the window between the arming read and the clearing write. A wrap in that window must cancel the clear, and this includes a wrap in the very cycle of the write. With the counter on the system clock, the wrap timing cannot be predicted from outside. The stimulus therefore sets the limit to zero and selects the external tick source. Each tick pulse from the bench then causes exactly one wrap in a cycle the bench chooses. Every read of the status word arms a clear, so the flag is observed through the interrupt line during these sequences, with the enable bit held at 1.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

    localparam int DATA_W    = 32;
    localparam int CS_W      = 2;
    localparam int PS_W      = 3;
    localparam int FLAG_BIT  = 7;
    localparam int IE_BIT    = 6;
    localparam int CS_LSB    = 3;
    localparam int PS_LSB    = 0;

    localparam int OFS_STAT  = 'h0;
    localparam int OFS_LIMIT = 'h4;
    localparam int OFS_COUNT = 'h8;

    typedef enum logic [CS_W-1:0] {
        SRC_OFF  = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_EXT2 = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic                flag;
        logic                ie;
        src_sel_e            src;
        logic [PS_W-1:0]     div;
    } stat_t;

    typedef struct packed {
        logic rd_stat;
        logic wr_stat;
        logic wr_limit;
        logic rd_limit;
        logic rd_count;
    } bus_dec_t;

    function automatic logic [DATA_W-1:0] pack_status(input stat_t s);
        logic [DATA_W-1:0] w;
        w                    = '0;
        w[FLAG_BIT]          = s.flag;
        w[IE_BIT]            = s.ie;
        w[CS_LSB +: CS_W]    = s.src;
        w[PS_LSB +: PS_W]    = s.div;
        return w;
    endfunction

    function automatic logic src_event(input src_sel_e sel, input logic tick);
        case (sel)
            SRC_OFF: return 1'b0;
            SRC_SYS: return 1'b1;
            default: return tick;
        endcase
    endfunction

endpackage

// File: rtl/ovf_tick_prescaler.sv
module ovf_tick_prescaler
    import ovf_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  src_sel_e        src,
    input  logic [PS_W-1:0] div,
    input  logic            tick_in,
    output logic            adv
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;
    logic             evt;

    always_comb begin
        evt  = src_event(src, tick_in);
        mask = ~({DIV_W{1'b1}} << div);
        adv  = evt && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || src == SRC_OFF) begin
            phase_q <= '0;
        end else if (adv) begin
            phase_q <= '0;
        end else if (evt) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/ovf_mod_counter.sv
module ovf_mod_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic at_top;

    always_comb begin
        at_top = (count >= limit);
        wrap   = adv && at_top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (adv) begin
            count <= at_top ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/ovf_stat_reg.sv
module ovf_stat_reg
    import ovf_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_stat,
    input  logic            wr_stat,
    input  logic            w_flag,
    input  logic            w_ie,
    input  logic [CS_W-1:0] w_src,
    input  logic [PS_W-1:0] w_div,
    input  logic            wrap,
    output stat_t           stat,
    output logic            armed
);
    logic clear_ok;

    always_comb begin
        clear_ok = wr_stat && armed && !w_flag && !wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat  <= '0;
            armed <= 1'b0;
        end else begin
            if (wr_stat) begin
                stat.ie  <= w_ie;
                stat.src <= src_sel_e'(w_src);
                stat.div <= w_div;
            end

            if (wrap) begin
                stat.flag <= 1'b1;
            end else if (clear_ok) begin
                stat.flag <= 1'b0;
            end

            if (wrap || wr_stat) begin
                armed <= 1'b0;
            end else if (rd_stat && stat.flag) begin
                armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ovf_timer_ctrl.sv
module ovf_timer_ctrl
    import ovf_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ovf_irq
);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(OFS_LIMIT);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

    bus_dec_t         dec;
    stat_t            stat_q;
    logic             armed_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] count_q;
    logic             adv_w;
    logic             wrap_w;
    logic             cur_flag;
    logic             cur_ie;
    logic [CS_W-1:0]  cur_src;
    logic             unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    always_comb begin
        dec.rd_stat  = bus_rd && (bus_addr == A_STAT);
        dec.wr_stat  = bus_wr && (bus_addr == A_STAT);
        dec.wr_limit = bus_wr && (bus_addr == A_LIMIT);
        dec.rd_limit = bus_rd && (bus_addr == A_LIMIT);
        dec.rd_count = bus_rd && (bus_addr == A_COUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
        end else if (dec.wr_limit) begin
            limit_q <= bus_wdata[CNT_W-1:0];
        end
    end

    ovf_stat_reg stat_i (
        .clk     (clk),
        .rst     (rst),
        .rd_stat (dec.rd_stat),
        .wr_stat (dec.wr_stat),
        .w_flag  (bus_wdata[FLAG_BIT]),
        .w_ie    (bus_wdata[IE_BIT]),
        .w_src   (bus_wdata[CS_LSB +: CS_W]),
        .w_div   (bus_wdata[PS_LSB +: PS_W]),
        .wrap    (wrap_w),
        .stat    (stat_q),
        .armed   (armed_q)
    );

    ovf_tick_prescaler presc_i (
        .clk     (clk),
        .rst     (rst),
        .src     (stat_q.src),
        .div     (stat_q.div),
        .tick_in (tick_in),
        .adv     (adv_w)
    );

    ovf_mod_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv_w),
        .limit (limit_q),
        .count (count_q),
        .wrap  (wrap_w)
    );

    always_comb begin
        cur_flag = stat_q.flag;
        cur_ie   = stat_q.ie;
        cur_src  = stat_q.src;
        ovf_irq  = cur_flag && cur_ie;
        unique case (1'b1)
            dec.rd_stat:  bus_rdata = pack_status(stat_q);
            dec.rd_limit: bus_rdata = DATA_W'(limit_q);
            dec.rd_count: bus_rdata = DATA_W'(count_q);
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             adv,
    input logic             wrap,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit,
    input logic             flag,
    input logic             armed,
    input logic             ie,
    input logic [1:0]       src,
    input logic             wr_stat,
    input logic             w_flag,
    input logic             rd_stat,
    input logic [31:0]      rdata,
    input logic             irq
);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && count < limit) |=> count == CNT_W'($past(count) + 1'b1));

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> count == '0);

    // R3
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src == 2'd0) |=> $stable(count));

    // R6
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(armed && wr_stat && !w_flag));

    // R8
    wrap_cancels_arm_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !armed);

    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !irq);

    // R9
    irq_rise_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> flag);

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stat |-> (rdata[31:8] == '0 && rdata[5] == 1'b0));

endmodule

bind ovf_timer_ctrl ovf_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv_w),
    .wrap    (wrap_w),
    .count   (count_q),
    .limit   (limit_q),
    .flag    (cur_flag),
    .armed   (armed_q),
    .ie      (cur_ie),
    .src     (cur_src),
    .wr_stat (dec.wr_stat),
    .w_flag  (bus_wdata[7]),
    .rd_stat (dec.rd_stat),
    .rdata   (bus_rdata),
    .irq     (ovf_irq)
);

// File: tb/ovf_timer_ctrl_tb.sv
module ovf_timer_ctrl_tb_top;
    localparam logic [3:0] A_STAT  = 4'h0;
    localparam logic [3:0] A_LIMIT = 4'h4;
    localparam logic [3:0] A_COUNT = 4'h8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_in = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ovf_irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    ovf_timer_ctrl #(.CNT_W(16), .ADDR_W(4)) dut_i (
        .clk(clk), .rst(rst), .tick_in(tick_in), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ovf_irq(ovf_irq)
    );

    function automatic logic [31:0] ctl(bit f, bit ie, int src, int dv);
        return (32'(f) << 7) | (32'(ie) << 6) | (32'(src & 3) << 3) | 32'(dv & 7);
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_in = 1'b1;
        @(posedge clk); #1;
        tick_in = 1'b0;
    endtask

    task automatic sample_irq(string req, string what, bit exp);
        @(negedge clk);
        check(req, what, 32'(ovf_irq), 32'(exp));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        check("R1", "irq after reset", 32'(ovf_irq), 0);
        bus_read(A_STAT, d);  check("R1", "status after reset", d, 0);
        bus_read(A_LIMIT, d); check("R1", "limit after reset", d, 0);
        bus_read(A_COUNT, d); check("R1", "count after reset", d, 0);
    endtask

    task automatic t_free_run();
        logic [31:0] d, prev;
        int wraps = 0;
        bus_write(A_LIMIT, 4);
        bus_write(A_STAT, ctl(0, 0, 1, 0));
        bus_read(A_COUNT, prev);
        for (int i = 0; i < 12; i++) begin
            bus_read(A_COUNT, d);
            check("R2", "count step every clock", d, (prev + 1) % 5);
            if (d == 0) wraps++;
            prev = d;
        end
        check("R2", "wraps seen in 12 cycles", 32'(wraps >= 2), 1);
        bus_write(A_STAT, ctl(1, 0, 0, 0));
        bus_read(A_STAT, d);
        check("R3", "flag after wraps", d, 32'h80);
    endtask

    task automatic t_stop();
        logic [31:0] d, v;
        bus_read(A_COUNT, v);
        repeat (10) @(negedge clk);
        bus_read(A_COUNT, d);
        check("R4", "stopped count holds", d, v);
    endtask

    task automatic t_prescale();
        logic [31:0] d, prev;
        int idx[3];
        int nchg = 0;
        bus_write(A_LIMIT, 100);
        bus_write(A_STAT, ctl(1, 0, 1, 2));
        bus_read(A_COUNT, prev);
        for (int i = 0; i < 30; i++) begin
            bus_read(A_COUNT, d);
            if (d != prev && nchg < 3) begin idx[nchg] = i; nchg++; end
            prev = d;
        end
        check("R5", "changes seen with divide by 4", 32'(nchg), 3);
        check("R5", "cycles between advances", 32'(idx[2] - idx[1]), 4);
        bus_write(A_STAT, ctl(1, 0, 0, 0));
    endtask

    task automatic t_ext_tick();
        logic [31:0] d, c0;
        bus_write(A_STAT, ctl(1, 0, 2, 1));
        bus_read(A_COUNT, c0);
        repeat (5) @(negedge clk);
        bus_read(A_COUNT, d);
        check("R4", "external source idle without tick", d, c0);
        repeat (6) pulse_tick();
        bus_read(A_COUNT, d);
        check("R5", "six ticks divided by 2", d, (c0 + 3) % 101);
    endtask

    task automatic t_clear_protocol();
        logic [31:0] d;
        bus_write(A_LIMIT, 0);
        bus_write(A_STAT, ctl(1, 1, 2, 0));
        bus_read(A_STAT, d);
        bus_write(A_STAT, ctl(0, 1, 2, 0));
        sample_irq("R6", "flag cleared by read then write 0", 0);
        pulse_tick();
        sample_irq("R3", "flag set by wrap", 1);
        bus_write(A_STAT, ctl(0, 1, 2, 0));
        sample_irq("R7", "write 0 without arming read", 1);
        bus_read(A_STAT, d);
        check("R10", "status readback with flag", d, 32'hD0);
        bus_write(A_STAT, ctl(1, 1, 2, 0));
        sample_irq("R7", "armed write of 1 keeps flag", 1);
        bus_write(A_STAT, ctl(0, 1, 2, 0));
        sample_irq("R7", "arm consumed by earlier write", 1);
        bus_read(A_STAT, d);
        bus_write(A_STAT, ctl(0, 1, 2, 0));
        sample_irq("R6", "read then write 0 clears", 0);
        bus_read(A_STAT, d);
        check("R6", "status after clear", d, 32'h50);
    endtask

    task automatic t_wrap_edge();
        logic [31:0] d;
        bus_write(A_LIMIT, 2);
        pulse_tick();
        pulse_tick();
        bus_read(A_COUNT, d);
        check("R2", "count at limit", d, 2);
        sample_irq("R3", "no flag before wrap", 0);
        pulse_tick();
        @(negedge clk);
        check("R3", "irq on wrap edge", 32'(ovf_irq), 1);
        bus_read(A_COUNT, d);
        check("R2", "count wrapped to 0", d, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        bus_write(A_LIMIT, 0);
        bus_read(A_STAT, d);
        pulse_tick();
        bus_write(A_STAT, ctl(0, 1, 2, 0));
        sample_irq("R8", "wrap between read and write", 1);
        bus_read(A_STAT, d);
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = ctl(0, 1, 2, 0); bus_wr = 1'b1; tick_in = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; tick_in = 1'b0;
        sample_irq("R8", "wrap in the clearing cycle", 1);
        bus_read(A_STAT, d);
        bus_write(A_STAT, ctl(0, 1, 2, 0));
        sample_irq("R6", "clear after quiet window", 0);
    endtask

    task automatic t_irq_gate();
        logic [31:0] d;
        pulse_tick();
        sample_irq("R9", "irq with flag and enable", 1);
        bus_write(A_STAT, ctl(1, 0, 2, 0));
        sample_irq("R9", "irq masked by enable 0", 0);
        bus_read(A_STAT, d);
        check("R9", "flag kept while masked", d, 32'h90);
        bus_write(A_STAT, ctl(1, 1, 2, 0));
        sample_irq("R9", "irq back on enable 1", 1);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        bus_read(A_STAT, d);
        bus_write(A_STAT, ctl(0, 0, 0, 0));
        bus_write(A_STAT, 32'hFFFF_FF7F);
        bus_read(A_STAT, d);
        check("R10", "reserved bits read zero", d, 32'h5F);
        bus_write(A_STAT, 32'h0000_0080);
        bus_read(A_STAT, d);
        check("R7", "write 1 does not set flag", d, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d, v;
        bus_write(A_LIMIT, 32'hFFFF_ABCD);
        bus_read(A_LIMIT, d);
        check("R11", "limit readback width", d, 32'h0000_ABCD);
        bus_read(A_COUNT, v);
        bus_write(A_COUNT, 32'h1234);
        bus_read(A_COUNT, d);
        check("R11", "count write ignored", d, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_free_run();
        t_stop();
        t_prescale();
        t_ext_tick();
        t_clear_protocol();
        t_wrap_edge();
        t_race();
        t_irq_gate();
        t_reserved();
        t_regs();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule